// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Logic

This block decides, every clock, how many instructions leave the decode queue of an in-order integer core that has two execution pipes. It looks at the two oldest decoded entries. The older one is always the candidate for the primary pipe (u), which accepts any instruction class. The younger one may join it in the secondary pipe (v) only when it belongs to a class that pipe can execute. It must also not depend on the older one through a register. When the younger entry cannot pair, the v pipe stays empty. That entry stays at the head of the queue and becomes the next cycle's u candidate. It never goes alone into v.

The decision is purely combinational towards the queue: a consume count of 0, 1 or 2 tells the queue how many entries to retire in the same cycle. The chosen instructions are captured in a one-stage issue latch that feeds the two pipes on the following cycle. A downstream stall blocks all issue. While it is asserted the latch presents no valid instruction and the queue is left untouched.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset, both issue outputs `u_valid` and `v_valid` are 0.
- R2: When `s0_valid` is 1 and `stall` is 0, on the next clock `u_valid` is 1 and the u fields (class, sources, destination, write flag) equal those of slot 0. The older instruction never appears on v.
- R3: Class codes are 0 simple, 1 complex, 2 floating point, 3 FP register exchange, 4 branch. A younger instruction of class 1 or 2 never pairs. Class 3 is the only floating-point code that may pair, and it may do so behind any non-branch older instruction.
- R4: An older instruction of class 4 (branch) always issues alone. A younger branch may pair.
- R5: No pairing when slot 0 writes (`s0_wr`=1) and either source of slot 1 equals `s0_dst`.
- R6: No pairing when both slots write and `s1_dst` equals `s0_dst`. Equal destinations do not block pairing when slot 0 does not write.
- R7: While `stall` is 1, `consume` is 0, and on the next clock `u_valid` and `v_valid` are 0.
- R8: `consume` is combinational in the same cycle: 2 when the pair issues, 1 when only u issues, 0 otherwise. It equals the number of valid issue outputs on the next clock.
- R9: When the pair issues, on the next clock `v_valid` is 1 and the v fields equal those of slot 1.
- R10: When `s0_valid` is 0, `consume` is 0 and nothing issues, whatever slot 1 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Downstream stall; blocks all issue |
| s0_valid | input | 1 | Oldest queue entry is present |
| s0_cls | input | 3 | Class code of the oldest entry |
| s0_srca | input | RW | First source register of the oldest entry |
| s0_srcb | input | RW | Second source register of the oldest entry |
| s0_dst | input | RW | Destination register of the oldest entry |
| s0_wr | input | 1 | Oldest entry writes its destination |
| s1_valid | input | 1 | Second-oldest entry is present |
| s1_cls | input | 3 | Class code of the second-oldest entry |
| s1_srca | input | RW | First source register of the second entry |
| s1_srcb | input | RW | Second source register of the second entry |
| s1_dst | input | RW | Destination register of the second entry |
| s1_wr | input | 1 | Second entry writes its destination |
| consume | output | 2 | Entries retired from the queue this cycle |
| u_valid | output | 1 | Primary pipe receives an instruction |
| u_cls | output | 3 | Class code issued to the primary pipe |
| u_srca | output | RW | First source issued to the primary pipe |
| u_srcb | output | RW | Second source issued to the primary pipe |
| u_dst | output | RW | Destination issued to the primary pipe |
| u_wr | output | 1 | Write flag issued to the primary pipe |
| v_valid | output | 1 | Secondary pipe receives an instruction |
| v_cls | output | 3 | Class code issued to the secondary pipe |
| v_srca | output | RW | First source issued to the secondary pipe |
| v_srcb | output | RW | Second source issued to the secondary pipe |
| v_dst | output | RW | Destination issued to the secondary pipe |
| v_wr | output | 1 | Write flag issued to the secondary pipe |

RW is $clog2(NREG), 3 at the default of eight registers.

## Verification
A class refusal and a register dependency can both block pairing in one cycle. A stall can also override a pair that would otherwise be legal. The directed cases provoke each refusal alone and then in combination, for example a complex younger entry that also reads the older destination, or a legal pair presented under stall. A long pseudo-random run uses a small register file, so that accidental dependencies often coincide with class refusals. A behavioural model in the bench predicts the consume count in the same cycle and the issue latch contents one clock later. Both are compared on every step.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [2:0] {
        CLS_SIMPLE  = 3'd0,
        CLS_COMPLEX = 3'd1,
        CLS_FP      = 3'd2,
        CLS_FXCH    = 3'd3,
        CLS_BRANCH  = 3'd4
    } insn_cls_e;

    localparam int CNT_W = 2;

endpackage

// File: rtl/pair_class_check.sv
module pair_class_check
    import pair_pkg::*;
(
    input  insn_cls_e older_cls,
    input  insn_cls_e younger_cls,
    output logic      older_may_lead,
    output logic      younger_v_ok
);

    always_comb begin
        // an older branch must issue alone
        older_may_lead = (older_cls != CLS_BRANCH);
        // secondary pipe: simple ops, the FP exchange, and a trailing branch
        unique case (younger_cls)
            CLS_SIMPLE, CLS_FXCH, CLS_BRANCH: younger_v_ok = 1'b1;
            default:                          younger_v_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
    parameter int RW   = 3,
    parameter int NSRC = 2
) (
    input  logic [RW-1:0]            older_dst,
    input  logic                     older_wr,
    input  logic [NSRC-1:0][RW-1:0]  young_src,
    input  logic [RW-1:0]            young_dst,
    input  logic                     young_wr,
    output logic                     conflict
);

    logic [NSRC-1:0] raw_hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign raw_hit[g] = older_wr && (young_src[g] == older_dst);
    end

    logic waw_hit;
    assign waw_hit  = older_wr && young_wr && (young_dst == older_dst);
    assign conflict = (|raw_hit) || waw_hit;

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import pair_pkg::*;
#(
    parameter  int NREG = 8,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stall,
    input  logic                s0_valid,
    input  logic [2:0]          s0_cls,
    input  logic [RW-1:0]       s0_srca,
    input  logic [RW-1:0]       s0_srcb,
    input  logic [RW-1:0]       s0_dst,
    input  logic                s0_wr,
    input  logic                s1_valid,
    input  logic [2:0]          s1_cls,
    input  logic [RW-1:0]       s1_srca,
    input  logic [RW-1:0]       s1_srcb,
    input  logic [RW-1:0]       s1_dst,
    input  logic                s1_wr,
    output logic [CNT_W-1:0]    consume,
    output logic                u_valid,
    output logic [2:0]          u_cls,
    output logic [RW-1:0]       u_srca,
    output logic [RW-1:0]       u_srcb,
    output logic [RW-1:0]       u_dst,
    output logic                u_wr,
    output logic                v_valid,
    output logic [2:0]          v_cls,
    output logic [RW-1:0]       v_srca,
    output logic [RW-1:0]       v_srcb,
    output logic [RW-1:0]       v_dst,
    output logic                v_wr
);

    typedef struct packed {
        insn_cls_e     cls;
        logic [RW-1:0] srca;
        logic [RW-1:0] srcb;
        logic [RW-1:0] dst;
        logic          wr;
    } slot_t;

    typedef struct packed {
        logic  u_on;
        logic  v_on;
        slot_t u;
        slot_t v;
    } latch_t;

    slot_t  slot0, slot1;
    latch_t st_d, st_q;
    logic   older_may_lead, younger_v_ok, dep_conflict, pair_ok;
    logic [CNT_W-1:0] take_d;

    always_comb begin
        slot0 = '{cls: insn_cls_e'(s0_cls), srca: s0_srca, srcb: s0_srcb,
                  dst: s0_dst, wr: s0_wr};
        slot1 = '{cls: insn_cls_e'(s1_cls), srca: s1_srca, srcb: s1_srcb,
                  dst: s1_dst, wr: s1_wr};
    end

    pair_class_check u_cls_chk (
        .older_cls      (slot0.cls),
        .younger_cls    (slot1.cls),
        .older_may_lead (older_may_lead),
        .younger_v_ok   (younger_v_ok)
    );

    pair_hazard #(.RW(RW), .NSRC(2)) u_haz (
        .older_dst (s0_dst),
        .older_wr  (s0_wr),
        .young_src ({s1_srcb, s1_srca}),
        .young_dst (s1_dst),
        .young_wr  (s1_wr),
        .conflict  (dep_conflict)
    );

    assign pair_ok = s1_valid && older_may_lead && younger_v_ok && !dep_conflict;

    always_comb begin
        st_d   = st_q;
        take_d = '0;
        st_d.u_on = 1'b0;
        st_d.v_on = 1'b0;
        if (!stall && s0_valid) begin
            st_d.u_on = 1'b1;
            st_d.u    = slot0;
            take_d    = CNT_W'(1);
            if (pair_ok) begin
                st_d.v_on = 1'b1;
                st_d.v    = slot1;
                take_d    = CNT_W'(2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign consume = take_d;
    assign u_valid = st_q.u_on;
    assign u_cls   = st_q.u.cls;
    assign u_srca  = st_q.u.srca;
    assign u_srcb  = st_q.u.srcb;
    assign u_dst   = st_q.u.dst;
    assign u_wr    = st_q.u.wr;
    assign v_valid = st_q.v_on;
    assign v_cls   = st_q.v.cls;
    assign v_srca  = st_q.v.srca;
    assign v_srcb  = st_q.v.srcb;
    assign v_dst   = st_q.v.dst;
    assign v_wr    = st_q.v.wr;

    // checks on the issued pair
    assert_v_needs_u_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v_valid |-> u_valid);
    assert_v_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_valid |-> (v_cls == 3'd0 || v_cls == 3'd3 || v_cls == 3'd4));
    assert_branch_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && u_cls == 3'd4) |-> !v_valid);
    assert_no_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_valid && u_wr) |-> (v_srca != u_dst && v_srcb != u_dst));
    assert_no_waw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_valid && u_wr && v_wr) |-> (v_dst != u_dst));
    assert_stall_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> consume == '0);
    assert_stall_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!u_valid && !v_valid));
    assert_take_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        consume <= CNT_W'(2) ##1 1'b1 |-> ($past(consume) == CNT_W'(u_valid) + CNT_W'(v_valid)));
    assert_empty_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_valid |-> consume == '0);

endmodule

// File: tb/tb_dual_issue_pair.sv
`timescale 1ns/100ps
module tb_dual_issue_pair;

    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0;
    logic s0_valid = 1'b0, s0_wr = 1'b0, s1_valid = 1'b0, s1_wr = 1'b0;
    logic [2:0] s0_cls = '0, s1_cls = '0;
    logic [RW-1:0] s0_srca = '0, s0_srcb = '0, s0_dst = '0;
    logic [RW-1:0] s1_srca = '0, s1_srcb = '0, s1_dst = '0;
    logic [1:0] consume;
    logic u_valid, u_wr, v_valid, v_wr;
    logic [2:0] u_cls, v_cls;
    logic [RW-1:0] u_srca, u_srcb, u_dst, v_srca, v_srcb, v_dst;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_issue_pair #(.NREG(8)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_srca(s0_srca), .s0_srcb(s0_srcb),
        .s0_dst(s0_dst), .s0_wr(s0_wr),
        .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_srca(s1_srca), .s1_srcb(s1_srcb),
        .s1_dst(s1_dst), .s1_wr(s1_wr),
        .consume(consume),
        .u_valid(u_valid), .u_cls(u_cls), .u_srca(u_srca), .u_srcb(u_srcb),
        .u_dst(u_dst), .u_wr(u_wr),
        .v_valid(v_valid), .v_cls(v_cls), .v_srca(v_srca), .v_srcb(v_srcb),
        .v_dst(v_dst), .v_wr(v_wr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference: returns how many entries leave the queue
    function automatic int model_take(bit st, bit v0, int c0, int d0, bit w0,
                                      bit v1, int c1, int a1, int b1, int d1, bit w1);
        bit v_class, lead, dep;
        if (st || !v0) return 0;
        if (!v1) return 1;
        v_class = (c1 == 0) || (c1 == 3) || (c1 == 4);
        lead    = (c0 != 4);
        dep     = w0 && ((a1 == d0) || (b1 == d0) || (w1 && d1 == d0));
        return (v_class && lead && !dep) ? 2 : 1;
    endfunction

    task automatic step(input string tag, input bit st,
                        input bit v0, input int c0, input int a0, input int b0,
                        input int d0, input bit w0,
                        input bit v1, input int c1, input int a1, input int b1,
                        input int d1, input bit w1);
        int exp_take;
        @(negedge clk);
        stall = st;
        s0_valid = v0; s0_cls = 3'(c0); s0_srca = RW'(a0); s0_srcb = RW'(b0);
        s0_dst = RW'(d0); s0_wr = w0;
        s1_valid = v1; s1_cls = 3'(c1); s1_srca = RW'(a1); s1_srcb = RW'(b1);
        s1_dst = RW'(d1); s1_wr = w1;
        #1;
        exp_take = model_take(st, v0, c0, d0, w0, v1, c1, a1 % 8, b1 % 8, d1 % 8, w1);
        chk(tag, "consume", 32'(consume), 32'(exp_take));
        @(posedge clk);
        #1;
        chk(tag, "u_valid", 32'(u_valid), 32'(exp_take >= 1));
        chk(tag, "v_valid", 32'(v_valid), 32'(exp_take == 2));
        if (exp_take >= 1) begin
            chk(tag, "u_cls", 32'(u_cls), 32'(c0));
            chk(tag, "u_srca", 32'(u_srca), 32'(a0 % 8));
            chk(tag, "u_srcb", 32'(u_srcb), 32'(b0 % 8));
            chk(tag, "u_dst", 32'(u_dst), 32'(d0 % 8));
            chk(tag, "u_wr", 32'(u_wr), 32'(w0));
        end
        if (exp_take == 2) begin
            chk(tag, "v_cls", 32'(v_cls), 32'(c1));
            chk(tag, "v_srca", 32'(v_srca), 32'(a1 % 8));
            chk(tag, "v_srcb", 32'(v_srcb), 32'(b1 % 8));
            chk(tag, "v_dst", 32'(v_dst), 32'(d1 % 8));
            chk(tag, "v_wr", 32'(v_wr), 32'(w1));
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "u_valid", 32'(u_valid), 32'd0);
        chk("R1", "v_valid", 32'(v_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 plain pair of simple ops, no dependency
        step("R9", 0, 1, 0, 1, 2, 3, 1,  1, 0, 4, 5, 6, 1);
        // R3 younger complex / FP blocked; FP + exchange pairs
        step("R3", 0, 1, 0, 1, 2, 3, 1,  1, 1, 4, 5, 6, 1);
        step("R3", 0, 1, 0, 1, 2, 3, 1,  1, 2, 4, 5, 6, 1);
        step("R3", 0, 1, 2, 1, 2, 3, 0,  1, 3, 4, 5, 6, 0);
        // R4 older branch alone; trailing branch pairs
        step("R4", 0, 1, 4, 1, 2, 3, 0,  1, 0, 4, 5, 6, 1);
        step("R4", 0, 1, 0, 1, 2, 3, 1,  1, 4, 4, 5, 6, 0);
        // R5 read after write on either source; no write means no hazard
        step("R5", 0, 1, 0, 1, 2, 3, 1,  1, 0, 3, 5, 6, 1);
        step("R5", 0, 1, 0, 1, 2, 3, 1,  1, 0, 4, 3, 6, 1);
        step("R5", 0, 1, 0, 1, 2, 3, 0,  1, 0, 3, 3, 6, 1);
        // R6 write after write; only one writer pairs
        step("R6", 0, 1, 0, 1, 2, 3, 1,  1, 0, 4, 5, 3, 1);
        step("R6", 0, 1, 0, 1, 2, 3, 0,  1, 0, 4, 5, 3, 1);
        step("R6", 0, 1, 0, 1, 2, 3, 1,  1, 0, 4, 5, 3, 0);
        // combined refusal: class and dependency together
        step("R3", 0, 1, 0, 1, 2, 3, 1,  1, 1, 3, 5, 3, 1);
        // R7 stall over a legal pair, then recovery
        step("R7", 1, 1, 0, 1, 2, 3, 1,  1, 0, 4, 5, 6, 1);
        step("R7", 1, 1, 4, 1, 2, 3, 1,  0, 0, 4, 5, 6, 1);
        step("R8", 0, 1, 0, 1, 2, 3, 1,  1, 0, 4, 5, 6, 1);
        // R10 empty head with a valid second entry
        step("R10", 0, 0, 0, 1, 2, 3, 1,  1, 0, 4, 5, 6, 1);
        // R8 single entry only
        step("R8", 0, 1, 1, 7, 0, 5, 1,  0, 0, 4, 5, 6, 1);

        // R2 pseudo-random run with a small register space
        for (int i = 0; i < 400; i++) begin
            step("R2", ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 7) != 0), $urandom_range(0, 4),
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 1),
                 ($urandom_range(0, 5) != 0), $urandom_range(0, 4),
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 1));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule